// File: doc/BRIEF.md
# Timer Compare Output Channel Stage

This block sits beside a general-purpose up/down counter and turns its running count into one output pin per channel. Each channel compares the shared count with its own compare value. A three-bit mode field decides how a per-channel reference level reacts. The mode can set a fixed action taken on a compare hit, hold the level at a forced value, or track the count as a PWM waveform. The reference level then goes through a polarity inverter and an enable gate to reach the pin. Each channel also gives a one-cycle event pulse when its compare hit occurs.

The counter, its prescaler and reload, input capture, dead-time and any register access are outside this block. The count is an input port. Every channel has two small state machines:

- **Hit detector.** States `DET_ARMED` and `DET_HELD`. The transition *arm-to-held* happens when the count equals the compare value. This transition is the compare hit, so a hit occurs only on the first cycle of equality. The transition *held-to-arm* happens when equality ends.
- **Reference machine.** States `REF_INACTIVE` and `REF_ACTIVE`. The transitions *activate* and *deactivate* are selected by the mode, the compare hit and the less-than comparison.

The PWM rule is the same whether the counter is counting up or down, so the block takes no direction input. Centre-aligned counting therefore gives symmetric pulses.

Top module: `tmr_cmp_out_stage`

## Requirements
- R1: While reset is held and in the first cycle after reset, every reference level is inactive (0) and `match_evt` is all zero. As a result, each `ch_out[i]` equals `ch_en[i] & pol_inv[i]`.
- R2: A compare hit for channel i is the first cycle in which `cnt_val` equals that channel's compare value, compared unsigned. The hit raises `match_evt[i]` for exactly one cycle, starting at the next clock edge. Equality that continues raises no further pulse. A new pulse needs at least one cycle of inequality first.
- R3: Mode 3'd0 (hold) never changes the reference level, including on a compare hit.
- R4: Mode 3'd1 makes the reference inactive and mode 3'd2 makes it active. In both modes the change happens at the clock edge that ends the hit cycle, and the output does not change before that edge.
- R5: Mode 3'd3 inverts the reference at the edge that ends each hit cycle.
- R6: Mode 3'd4 drives the reference inactive at every edge and mode 3'd5 drives it active at every edge, whatever the count or compare values are.
- R7: Mode 3'd6 sets the reference at each edge to active when `cnt_val < cmp` (unsigned) and to inactive otherwise. Mode 3'd7 sets the opposite level. The rule is the same for rising and falling counts, and a compare value of 0 keeps mode 3'd6 inactive.
- R8: When `pol_inv[i]` is 1, `ch_out[i]` is the inverse of the reference level. The polarity takes effect in the same cycle, with no clock edge needed.
- R9: When `ch_en[i]` is 0, `ch_out[i]` is 0. The reference level keeps updating while the channel is disabled, and it appears at the pin in the same cycle the enable returns.
- R10: A change of mode leaves the reference level as it is until the next event that the new mode acts on.
- R11: Channel i takes its compare value from `cmp_val[CW*i +: CW]` and its mode from `mode_sel[3*i +: 3]`. Channels do not affect one another's events or levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CW (16) | Shared counter value |
| cmp_val | input | NCH*CW (64) | Per-channel compare values, channel i at [CW*i +: CW] |
| mode_sel | input | NCH*3 (12) | Per-channel mode field, channel i at [3*i +: 3] |
| pol_inv | input | NCH (4) | Per-channel polarity; 1 inverts the reference |
| ch_en | input | NCH (4) | Per-channel output enable; 0 holds the pin at 0 |
| ch_out | output | NCH (4) | Channel output pins |
| match_evt | output | NCH (4) | One-cycle compare-event pulse per channel |

## Verification
A compare hit updates the reference level and raises the event pulse on the same clock edge. A polarity or enable change applies to the pin in the same cycle that a reference update becomes visible. The bench creates these overlaps by making the count equal to the compare value. In the cycle after the edge it checks the event bit and the pin level together. It also toggles polarity or enable between edges and confirms that the pin follows immediately, while the registered reference keeps its value.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

    typedef enum logic [2:0] {
        OM_HOLD     = 3'd0,
        OM_CLR      = 3'd1,
        OM_SET      = 3'd2,
        OM_TGL      = 3'd3,
        OM_FORCE_LO = 3'd4,
        OM_FORCE_HI = 3'd5,
        OM_PWM_A    = 3'd6,
        OM_PWM_B    = 3'd7
    } om_e;

    typedef enum logic {
        DET_ARMED = 1'b0,
        DET_HELD  = 1'b1
    } det_state_e;

    typedef enum logic {
        REF_INACTIVE = 1'b0,
        REF_ACTIVE   = 1'b1
    } ref_state_e;

    localparam int MODE_W = 3;

endpackage

// File: rtl/tmr_match_det.sv
module tmr_match_det
    import tmr_cmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    output logic          hit,
    output logic          below,
    output logic          evt
);

    det_state_e st_q;
    det_state_e st_d;
    logic       eq;

    assign eq    = (cnt == cmp);
    assign below = (cnt < cmp);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DET_ARMED;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and hit output
    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        unique case (st_q)
            DET_ARMED: begin
                if (eq) begin
                    hit  = 1'b1;
                    st_d = DET_HELD;
                end
            end
            DET_HELD: begin
                if (!eq) begin
                    st_d = DET_ARMED;
                end
            end
            default: st_d = DET_ARMED;
        endcase
    end

    // one-cycle event pulse, aligned with the reference update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt <= 1'b0;
        end else begin
            evt <= hit;
        end
    end

endmodule

// File: rtl/tmr_ref_fsm.sv
module tmr_ref_fsm
    import tmr_cmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  om_e  mode,
    input  logic hit,
    input  logic below,
    output logic ref_lvl
);

    ref_state_e st_q;
    ref_state_e st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= REF_INACTIVE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions chosen by mode
    always_comb begin
        st_d = st_q;
        unique case (mode)
            OM_HOLD: begin
                st_d = st_q;
            end
            OM_CLR: begin
                if (hit) st_d = REF_INACTIVE;
            end
            OM_SET: begin
                if (hit) st_d = REF_ACTIVE;
            end
            OM_TGL: begin
                if (hit) begin
                    st_d = (st_q == REF_ACTIVE) ? REF_INACTIVE : REF_ACTIVE;
                end
            end
            OM_FORCE_LO: st_d = REF_INACTIVE;
            OM_FORCE_HI: st_d = REF_ACTIVE;
            OM_PWM_A:    st_d = below ? REF_ACTIVE : REF_INACTIVE;
            OM_PWM_B:    st_d = below ? REF_INACTIVE : REF_ACTIVE;
            default:     st_d = st_q;
        endcase
    end

    // output process
    always_comb begin
        ref_lvl = (st_q == REF_ACTIVE);
    end

endmodule

// File: rtl/tmr_pin_gate.sv
module tmr_pin_gate (
    input  logic ref_lvl,
    input  logic pol,
    input  logic en,
    output logic pin
);

    always_comb begin
        pin = en ? (ref_lvl ^ pol) : 1'b0;
    end

endmodule

// File: rtl/tmr_cmp_out_stage.sv
module tmr_cmp_out_stage
    import tmr_cmp_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CW-1:0]      cnt_val,
    input  logic [NCH*CW-1:0]  cmp_val,
    input  logic [NCH*3-1:0]   mode_sel,
    input  logic [NCH-1:0]     pol_inv,
    input  logic [NCH-1:0]     ch_en,
    output logic [NCH-1:0]     ch_out,
    output logic [NCH-1:0]     match_evt
);

    localparam int MW = MODE_W;

    logic [NCH-1:0] hit;
    logic [NCH-1:0] below;
    logic [NCH-1:0] ref_lvl;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_match_det #(
            .CW (CW)
        ) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt_val),
            .cmp   (cmp_val[CW*i +: CW]),
            .hit   (hit[i]),
            .below (below[i]),
            .evt   (match_evt[i])
        );

        tmr_ref_fsm u_ref (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (om_e'(mode_sel[MW*i +: MW])),
            .hit     (hit[i]),
            .below   (below[i]),
            .ref_lvl (ref_lvl[i])
        );

        tmr_pin_gate u_gate (
            .ref_lvl (ref_lvl[i]),
            .pol     (pol_inv[i]),
            .en      (ch_en[i]),
            .pin     (ch_out[i])
        );
    end

endmodule

// File: rtl/tmr_cmp_out_chk.sv
module tmr_cmp_out_chk
    import tmr_cmp_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW-1:0]     cnt_val,
    input logic [NCH*CW-1:0] cmp_val,
    input logic [NCH*3-1:0]  mode_sel,
    input logic [NCH-1:0]    pol_inv,
    input logic [NCH-1:0]    ch_en,
    input logic [NCH-1:0]    ch_out,
    input logic [NCH-1:0]    match_evt
);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_evt_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
            match_evt[i] |=> !match_evt[i]);

        p_evt_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
            match_evt[i] |-> $past(cnt_val == cmp_val[CW*i +: CW]));

        p_hold_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(mode_sel[3*i +: 3]) == 3'd0) && $past(ch_en[i])
             && ch_en[i] && $stable(pol_inv[i])) |-> $stable(ch_out[i]));

        p_force_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(mode_sel[3*i +: 3]) == 3'd5) && ch_en[i])
            |-> (ch_out[i] == !pol_inv[i]));

        p_force_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(mode_sel[3*i +: 3]) == 3'd4) && ch_en[i])
            |-> (ch_out[i] == pol_inv[i]));

        p_pwm_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(mode_sel[3*i +: 3]) == 3'd6) && ch_en[i])
            |-> (ch_out[i] == ($past(cnt_val < cmp_val[CW*i +: CW]) ^ pol_inv[i])));

        p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[i] |-> !ch_out[i]);
    end

endmodule

bind tmr_cmp_out_stage tmr_cmp_out_chk #(
    .NCH (NCH),
    .CW  (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_val   (cnt_val),
    .cmp_val   (cmp_val),
    .mode_sel  (mode_sel),
    .pol_inv   (pol_inv),
    .ch_en     (ch_en),
    .ch_out    (ch_out),
    .match_evt (match_evt)
);

// File: tb/tmr_cmp_out_stage_bench.sv
`timescale 1ns/1ps
module tmr_cmp_out_stage_bench;

    localparam int NCH = 4;
    localparam int CW  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [CW-1:0]     cnt_val;
    logic [NCH*CW-1:0] cmp_val;
    logic [NCH*3-1:0]  mode_sel;
    logic [NCH-1:0]    pol_inv;
    logic [NCH-1:0]    ch_en;
    logic [NCH-1:0]    ch_out;
    logic [NCH-1:0]    match_evt;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    tmr_cmp_out_stage #(.NCH(NCH), .CW(CW)) u_tmr_cmp_out_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_val   (cnt_val),
        .cmp_val   (cmp_val),
        .mode_sel  (mode_sel),
        .pol_inv   (pol_inv),
        .ch_en     (ch_en),
        .ch_out    (ch_out),
        .match_evt (match_evt)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input logic [2:0] m, input logic [CW-1:0] c,
                       input logic p, input logic e);
        mode_sel[ch*3 +: 3] = m;
        cmp_val[ch*CW +: CW] = c;
        pol_inv[ch] = p;
        ch_en[ch]   = e;
    endtask

    task automatic park(input int ch);
        cfg(ch, 3'd0, CW'(1000 + ch), 1'b0, 1'b1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cnt_val = '0;
        for (int i = 0; i < NCH; i++) park(i);
        pol_inv = 4'b0101;
        repeat (3) tick();
        chk("R1 out during reset", 32'(ch_out), 32'h5);
        rst_n = 1'b1;
        tick();
        chk("R1 out after reset", 32'(ch_out), 32'h5);
        chk("R1 evt after reset", 32'(match_evt), 32'h0);
        pol_inv = '0;
    endtask

    task automatic t_event();
        cfg(0, 3'd0, 16'd10, 1'b0, 1'b1);
        cnt_val = 16'd5;
        tick();
        chk("R2 no evt when unequal", 32'(match_evt[0]), 32'h0);
        cnt_val = 16'd10;
        tick();
        chk("R2 evt after hit", 32'(match_evt[0]), 32'h1);
        chk("R3 hold keeps level", 32'(ch_out[0]), 32'h0);
        tick();
        chk("R2 no repeat on held equality", 32'(match_evt[0]), 32'h0);
        cnt_val = 16'd11;
        tick();
        cnt_val = 16'd10;
        tick();
        chk("R2 re-armed evt", 32'(match_evt[0]), 32'h1);
        chk("R3 hold keeps level again", 32'(ch_out[0]), 32'h0);
        park(0);
    endtask

    task automatic t_set_clr();
        cfg(1, 3'd4, 16'd20, 1'b0, 1'b1);
        cnt_val = 16'd0;
        tick();
        cfg(1, 3'd2, 16'd20, 1'b0, 1'b1);
        tick();
        chk("R4 set idle before hit", 32'(ch_out[1]), 32'h0);
        cnt_val = 16'd20;
        #1;
        chk("R4 no change before edge", 32'(ch_out[1]), 32'h0);
        tick();
        chk("R4 set on hit", 32'(ch_out[1]), 32'h1);
        cfg(1, 3'd1, 16'd20, 1'b0, 1'b1);
        cnt_val = 16'd21;
        tick();
        chk("R10 mode change keeps level", 32'(ch_out[1]), 32'h1);
        cnt_val = 16'd20;
        tick();
        chk("R4 clear on hit", 32'(ch_out[1]), 32'h0);
        park(1);
    endtask

    task automatic t_toggle();
        cfg(2, 3'd4, 16'd30, 1'b0, 1'b1);
        cnt_val = 16'd0;
        tick();
        cfg(2, 3'd3, 16'd30, 1'b0, 1'b1);
        cnt_val = 16'd30;
        tick();
        chk("R5 first toggle", 32'(ch_out[2]), 32'h1);
        cnt_val = 16'd31;
        tick();
        chk("R5 no toggle off hit", 32'(ch_out[2]), 32'h1);
        cnt_val = 16'd30;
        tick();
        chk("R5 second toggle", 32'(ch_out[2]), 32'h0);
        park(2);
    endtask

    task automatic t_force();
        cfg(3, 3'd5, 16'd0, 1'b0, 1'b1);
        cnt_val = 16'd999;
        tick();
        chk("R6 force active", 32'(ch_out[3]), 32'h1);
        cfg(3, 3'd4, 16'd0, 1'b0, 1'b1);
        cnt_val = 16'd0;
        tick();
        chk("R6 force inactive on equal", 32'(ch_out[3]), 32'h0);
        park(3);
    endtask

    task automatic t_pwm();
        cfg(0, 3'd6, 16'd8, 1'b0, 1'b1);
        for (int c = 0; c < 16; c++) begin
            cnt_val = CW'(c);
            tick();
            chk("R7 pwm A rising", 32'(ch_out[0]), 32'(c < 8));
        end
        for (int c = 15; c >= 0; c--) begin
            cnt_val = CW'(c);
            tick();
            chk("R7 pwm A falling", 32'(ch_out[0]), 32'(c < 8));
        end
        cfg(0, 3'd7, 16'd8, 1'b0, 1'b1);
        for (int c = 6; c < 11; c++) begin
            cnt_val = CW'(c);
            tick();
            chk("R7 pwm B", 32'(ch_out[0]), 32'(c >= 8));
        end
        cfg(0, 3'd6, 16'd0, 1'b0, 1'b1);
        cnt_val = 16'd0;
        tick();
        chk("R7 pwm A zero compare", 32'(ch_out[0]), 32'h0);
        cfg(0, 3'd7, 16'd0, 1'b0, 1'b1);
        tick();
        chk("R7 pwm B zero compare", 32'(ch_out[0]), 32'h1);
        park(0);
    endtask

    task automatic t_polarity();
        cfg(3, 3'd5, 16'd1003, 1'b1, 1'b1);
        tick();
        chk("R8 inverted active", 32'(ch_out[3]), 32'h0);
        pol_inv[3] = 1'b0;
        #1;
        chk("R8 polarity immediate", 32'(ch_out[3]), 32'h1);
        park(3);
    endtask

    task automatic t_enable();
        cfg(2, 3'd5, 16'd1002, 1'b0, 1'b0);
        tick();
        chk("R9 disabled idle", 32'(ch_out[2]), 32'h0);
        ch_en[2] = 1'b1;
        #1;
        chk("R9 level kept under disable", 32'(ch_out[2]), 32'h1);
        cfg(2, 3'd4, 16'd1002, 1'b1, 1'b0);
        tick();
        chk("R9 disabled ignores polarity", 32'(ch_out[2]), 32'h0);
        park(2);
    endtask

    task automatic t_indep();
        cfg(0, 3'd4, 16'd1000, 1'b0, 1'b1);
        cfg(1, 3'd5, 16'd1001, 1'b0, 1'b1);
        cnt_val = 16'd0;
        tick();
        cfg(0, 3'd2, 16'd40, 1'b0, 1'b1);
        cfg(1, 3'd1, 16'd41, 1'b0, 1'b1);
        cnt_val = 16'd40;
        tick();
        chk("R11 evt only ch0", 32'(match_evt), 32'h1);
        chk("R11 levels after ch0 hit", 32'(ch_out[1:0]), 32'h3);
        cnt_val = 16'd41;
        tick();
        chk("R11 evt only ch1", 32'(match_evt), 32'h2);
        chk("R11 levels after ch1 hit", 32'(ch_out[1:0]), 32'h1);
        park(0);
        park(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_event();
        t_set_clr();
        t_toggle();
        t_force();
        t_pwm();
        t_polarity();
        t_enable();
        t_indep();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule